// File: doc/BRIEF.md
# Partitioned Front-End Readout Sequencer

This block runs acquisition and readout for a group of front-end readout chips split into partitions. Each chip holds a small event memory and raises a buffer-full flag when that memory is exhausted. The sequencer either follows external start, stop and trigger commands, or runs its own repeating burst cycle of acquire time followed by idle time. As soon as any chip reports full, acquisition is paused. The flagged chips are read out, and acquisition resumes only once they are all drained.

Readout runs on a slow readout clock enable derived from the system clock. Each chip is emitted as a frame: one identifier word generated by the sequencer, then the timestamp words and then the sample words, both fetched from the chip by word address. In sequential mode the partitions take turns on one shared output lane. In concurrent mode every partition streams on its own lane at the same time. Every word carries a valid strobe, a partition tag and a frame-end marker.

Top module: `fe_readout_seq`

## Requirements
- R1: Each chip frame is FRAME = 1 + EVENTS + EVENTS*CHANNELS words. The first word is the identifier {4'hC, 4'h0, global index[7:0]}, with global index = partition*CHIPS_PER_PART + chip. It is followed by the words the chip returns for word addresses 0 to FRAME-2, in that order.
- R2: `lane_last` is high together with the final word of each chip frame and with no other word.
- R3: Within a partition, flagged chips are read in ascending chip index. Chips whose flag was clear when readout began produce no words.
- R4: In sequential mode (`cfg_parallel`=0), every word appears on lane 0, with partitions in ascending order, tagged with their source partition.
- R5: In concurrent mode (`cfg_parallel`=1), partition p streams only on lane p with tag p, and the lanes run at the same time.
- R6: A lane presents at most one valid word per RO_DIV system cycles.
- R7: `busy` rises on the clock edge after a chip flag is seen. It stays high until every flagged chip is drained. `acq_active` is low while `busy` is high or any flag is set, and returns afterwards if acquisition is still requested.
- R8: In external mode (`cfg_local`=0), `ext_start` raises `acq_active` two cycles later and `ext_stop` lowers it two cycles later. An `ext_start` received while `busy` is high or a flag is set is ignored.
- R9: In external mode, `chip_trig` equals `ext_trig` delayed by one cycle, gated by `acq_active`. It stays low when acquisition is off.
- R10: `full_up` is the OR of all chip flags delayed by one cycle in external mode, and is held low in local mode.
- R11: In local mode (`cfg_local`=1), `acq_active` alternates between BURST_CYC cycles high and GAP_CYC cycles low, with no effect from `ext_start` or `ext_stop`.
- R12: After reset, `busy`, `acq_active`, `chip_trig`, `full_up` and every `lane_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_local | input | 1 | 1: self-managed burst cycle, 0: external commands |
| cfg_parallel | input | 1 | 1: all partitions concurrently, 0: one after another |
| ext_trig | input | 1 | External trigger command |
| ext_start | input | 1 | External start-of-acquisition command |
| ext_stop | input | 1 | External stop-of-acquisition command |
| chip_full | input | N_PART*CHIPS_PER_PART | Buffer-full flag per chip, index partition*CHIPS_PER_PART+chip |
| rd_data | input | N_PART*16 | Word returned by the selected chip of each partition |
| rd_req | output | N_PART | Word fetch strobe per partition |
| rd_sel | output | N_PART*CW | Selected chip per partition |
| rd_addr | output | N_PART*AW | Word address within the chip memory |
| rd_last | output | N_PART | Fetch is the last word of the chip |
| lane_valid | output | N_PART | Word valid per output lane |
| lane_data | output | N_PART*16 | Output word per lane |
| lane_tag | output | N_PART*PW | Source partition of the word |
| lane_last | output | N_PART | Last word of a chip frame |
| busy | output | 1 | Readout in progress |
| acq_active | output | 1 | Chips may acquire |
| chip_trig | output | 1 | Trigger forwarded to the chips |
| full_up | output | 1 | Buffer-full status returned upstream |

## Verification
Each control result has a fixed latency. `chip_trig` and `full_up` follow their cause by one edge. `busy` rises one edge after a flag becomes visible. `acq_active` follows a start or stop by two edges, and follows the end of `busy` by one edge. The bench drives inputs just after a falling edge and checks at the falling edge that lies the stated number of rising edges later. Readout words arrive one cycle after a readout tick, and their timing depends on the divider phase. For that reason a monitor compares them by order, not by cycle, against a frame list built from the requirements, and counts per lane are checked once `busy` has dropped. Burst lengths in local mode are measured by counting cycles between edges of `acq_active`.

// File: rtl/fe_ro_pkg.sv
// Shared types and helpers for the partitioned readout sequencer.
// Assumes 16-bit words on every chip link and output lane.
package fe_ro_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_SCAN,
        RD_XFER
    } rd_state_t;

    // Identifier word placed at the head of every chip frame.
    function automatic logic [WORD_W-1:0] id_word(input int unsigned gidx);
        logic [31:0] g;
        g = gidx;
        return {4'hC, 4'h0, g[7:0]};
    endfunction

endpackage

// File: rtl/fe_ro_tick.sv
// Readout clock enable: one-cycle pulse every DIV system cycles.
// Assumes DIV >= 1; DIV = 1 gives a pulse every cycle.
module fe_ro_tick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CNW-1:0] cnt;

    // Count system cycles and pulse on the last one of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CNW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/fe_acq_ctrl.sv
// Acquisition mode control. External mode follows start/stop/trigger
// and reports buffer-full upstream; local mode runs a burst/gap cycle.
// Assumes busy and any_full come from the readout controller of the
// same clock domain.
module fe_acq_ctrl #(
    parameter int BURST_CYC = 1000,
    parameter int GAP_CYC   = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_local,
    input  logic ext_start,
    input  logic ext_stop,
    input  logic ext_trig,
    input  logic busy,
    input  logic any_full,
    output logic acq_active,
    output logic chip_trig,
    output logic full_up
);
    localparam int MAXC = (BURST_CYC > GAP_CYC) ? BURST_CYC : GAP_CYC;
    localparam int BW   = $clog2(MAXC + 1);

    logic          acq_on;
    logic          burst_on;
    logic [BW-1:0] burst_cnt;
    logic          want;

    // External run request: stop wins, start only accepted when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acq_on <= 1'b0;
        else if (ext_stop)
            acq_on <= 1'b0;
        else if (ext_start && !busy && !any_full)
            acq_on <= 1'b1;
    end

    // Local burst timer, frozen while chips are full or being drained.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg_local) begin
            burst_on  <= 1'b1;
            burst_cnt <= '0;
        end else if (!busy && !any_full) begin
            if (burst_on && burst_cnt == BW'(BURST_CYC - 1)) begin
                burst_on  <= 1'b0;
                burst_cnt <= '0;
            end else if (!burst_on && burst_cnt == BW'(GAP_CYC - 1)) begin
                burst_on  <= 1'b1;
                burst_cnt <= '0;
            end else begin
                burst_cnt <= burst_cnt + 1'b1;
            end
        end
    end

    assign want = cfg_local ? burst_on : acq_on;

    // Registered outputs toward the chips and upstream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_active <= 1'b0;
            chip_trig  <= 1'b0;
            full_up    <= 1'b0;
        end else begin
            acq_active <= want && !busy && !any_full;
            chip_trig  <= ext_trig && acq_active && !cfg_local;
            full_up    <= any_full && !cfg_local;
        end
    end

    p_trig_needs_acq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        chip_trig |-> $past(acq_active) && !$past(cfg_local));

    p_local_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_local && $past(cfg_local)) |-> !full_up);

    p_busy_blocks_acq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !acq_active);
endmodule

// File: rtl/fe_part_reader.sv
// Per-partition reader: walks the flagged chips of its partition in
// ascending order and emits one frame per chip, one word per tick.
// Assumes the chip answers rd_data combinationally for rd_sel/rd_addr.
module fe_part_reader
    import fe_ro_pkg::*;
#(
    parameter int CPP   = 4,
    parameter int FRAME = 1041,
    parameter int AW    = 11,
    parameter int CW    = 3,
    parameter int GBASE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              go,
    input  logic [CPP-1:0]    full_snap,
    input  logic [WORD_W-1:0] rd_data,
    output logic              rd_req,
    output logic [CW-1:0]     rd_sel,
    output logic [AW-1:0]     rd_addr,
    output logic              rd_last,
    output logic              w_valid,
    output logic [WORD_W-1:0] w_data,
    output logic              w_last,
    output logic              done,
    output logic              active
);
    rd_state_t      state;
    logic [CPP-1:0] mask;
    logic [CW-1:0]  chip;
    logic [AW-1:0]  widx;
    logic [CPP-1:0] shifted;
    logic           at_end;
    logic           frame_end;

    assign shifted   = mask >> chip;
    assign at_end    = (chip == CW'(CPP));
    assign frame_end = (widx == AW'(FRAME - 1));

    // Fetch side toward the chip: word 0 is generated locally.
    assign rd_req  = (state == RD_XFER) && tick && (widx != '0);
    assign rd_sel  = chip;
    assign rd_addr = widx - 1'b1;
    assign rd_last = frame_end;
    assign active  = (state != RD_IDLE);

    // Scan flagged chips and stream each frame on the readout tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RD_IDLE;
            mask    <= '0;
            chip    <= '0;
            widx    <= '0;
            w_valid <= 1'b0;
            w_data  <= '0;
            w_last  <= 1'b0;
            done    <= 1'b0;
        end else begin
            w_valid <= 1'b0;
            w_last  <= 1'b0;
            done    <= 1'b0;
            case (state)
                RD_IDLE: begin
                    if (go) begin
                        mask  <= full_snap;
                        chip  <= '0;
                        state <= RD_SCAN;
                    end
                end
                RD_SCAN: begin
                    if (at_end) begin
                        done  <= 1'b1;
                        state <= RD_IDLE;
                    end else if (shifted[0]) begin
                        widx  <= '0;
                        state <= RD_XFER;
                    end else begin
                        chip <= chip + 1'b1;
                    end
                end
                RD_XFER: begin
                    if (tick) begin
                        w_valid <= 1'b1;
                        w_data  <= (widx == '0) ? id_word(GBASE + int'(chip)) : rd_data;
                        w_last  <= frame_end;
                        if (frame_end) begin
                            chip  <= chip + 1'b1;
                            state <= RD_SCAN;
                        end else begin
                            widx <= widx + 1'b1;
                        end
                    end
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

    p_read_flagged_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> shifted[0]);

    p_last_is_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        w_last |-> w_valid);
endmodule

// File: rtl/fe_readout_seq.sv
// Top of the readout sequencer: snapshots buffer-full flags, runs the
// partition readers sequentially or concurrently, maps reader words to
// output lanes and drives acquisition control.
// Assumes a chip flag stays set until its last word has been fetched.
module fe_readout_seq
    import fe_ro_pkg::*;
#(
    parameter int N_PART         = 4,
    parameter int CHIPS_PER_PART = 4,
    parameter int EVENTS         = 16,
    parameter int CHANNELS       = 64,
    parameter int RO_DIV         = 8,
    parameter int BURST_CYC      = 1000,
    parameter int GAP_CYC        = 200,
    localparam int NCH   = N_PART * CHIPS_PER_PART,
    localparam int FRAME = 1 + EVENTS + EVENTS * CHANNELS,
    localparam int AW    = $clog2(FRAME),
    localparam int CW    = $clog2(CHIPS_PER_PART + 1),
    localparam int PW    = (N_PART > 1) ? $clog2(N_PART) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_local,
    input  logic                   cfg_parallel,
    input  logic                   ext_trig,
    input  logic                   ext_start,
    input  logic                   ext_stop,
    input  logic [NCH-1:0]         chip_full,
    input  logic [N_PART*16-1:0]   rd_data,
    output logic [N_PART-1:0]      rd_req,
    output logic [N_PART*CW-1:0]   rd_sel,
    output logic [N_PART*AW-1:0]   rd_addr,
    output logic [N_PART-1:0]      rd_last,
    output logic [N_PART-1:0]      lane_valid,
    output logic [N_PART*16-1:0]   lane_data,
    output logic [N_PART*PW-1:0]   lane_tag,
    output logic [N_PART-1:0]      lane_last,
    output logic                   busy,
    output logic                   acq_active,
    output logic                   chip_trig,
    output logic                   full_up
);
    logic                tick;
    logic                any_full;
    logic [NCH-1:0]      snap;
    logic [N_PART-1:0]   go;
    logic [N_PART-1:0]   done;
    logic [N_PART-1:0]   done_seen;
    logic [N_PART-1:0]   rdr_active;
    logic [N_PART-1:0]   w_valid;
    logic [N_PART-1:0]   w_last;
    logic [N_PART*WORD_W-1:0] w_data;
    logic                par_q;
    logic [PW-1:0]       seq_idx;

    assign any_full = |chip_full;

    fe_ro_tick #(.DIV(RO_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    fe_acq_ctrl #(.BURST_CYC(BURST_CYC), .GAP_CYC(GAP_CYC)) u_acq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_local (cfg_local),
        .ext_start (ext_start),
        .ext_stop  (ext_stop),
        .ext_trig  (ext_trig),
        .busy      (busy),
        .any_full  (any_full),
        .acq_active(acq_active),
        .chip_trig (chip_trig),
        .full_up   (full_up)
    );

    for (genvar p = 0; p < N_PART; p++) begin : g_rdr
        fe_part_reader #(
            .CPP  (CHIPS_PER_PART),
            .FRAME(FRAME),
            .AW   (AW),
            .CW   (CW),
            .GBASE(p * CHIPS_PER_PART)
        ) u_rdr (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .go       (go[p]),
            .full_snap(snap[p*CHIPS_PER_PART +: CHIPS_PER_PART]),
            .rd_data  (rd_data[p*16 +: 16]),
            .rd_req   (rd_req[p]),
            .rd_sel   (rd_sel[p*CW +: CW]),
            .rd_addr  (rd_addr[p*AW +: AW]),
            .rd_last  (rd_last[p]),
            .w_valid  (w_valid[p]),
            .w_data   (w_data[p*WORD_W +: WORD_W]),
            .w_last   (w_last[p]),
            .done     (done[p]),
            .active   (rdr_active[p])
        );
    end

    // Readout arbitration: snapshot flags, launch readers, track completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            snap      <= '0;
            go        <= '0;
            done_seen <= '0;
            par_q     <= 1'b0;
            seq_idx   <= '0;
        end else begin
            go <= '0;
            if (!busy) begin
                if (any_full) begin
                    busy      <= 1'b1;
                    snap      <= chip_full;
                    par_q     <= cfg_parallel;
                    done_seen <= '0;
                    seq_idx   <= '0;
                    go        <= cfg_parallel ? '1 : N_PART'(1);
                end
            end else if (par_q) begin
                done_seen <= done_seen | done;
                if (&(done_seen | done))
                    busy <= 1'b0;
            end else if (done[seq_idx]) begin
                if (seq_idx == PW'(N_PART - 1)) begin
                    busy <= 1'b0;
                end else begin
                    seq_idx <= seq_idx + 1'b1;
                    go      <= N_PART'(1) << (seq_idx + 1'b1);
                end
            end
        end
    end

    // Lane mapping: own lane per partition, or everything onto lane 0.
    always_comb begin
        logic [WORD_W-1:0] d_acc;
        logic [PW-1:0]     t_acc;
        lane_valid = '0;
        lane_data  = '0;
        lane_tag   = '0;
        lane_last  = '0;
        d_acc      = '0;
        t_acc      = '0;
        if (par_q) begin
            lane_valid = w_valid;
            lane_data  = w_data;
            lane_last  = w_last;
            for (int p = 0; p < N_PART; p++)
                lane_tag[p*PW +: PW] = PW'(p);
        end else begin
            for (int p = 0; p < N_PART; p++) begin
                if (w_valid[p]) begin
                    d_acc = d_acc | w_data[p*WORD_W +: WORD_W];
                    t_acc = t_acc | PW'(p);
                end
            end
            lane_valid[0]     = |w_valid;
            lane_last[0]      = |w_last;
            lane_data[15:0]   = d_acc;
            lane_tag[PW-1:0]  = t_acc;
        end
    end

    p_seq_one_reader_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !par_q) |-> $onehot0(rdr_active));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lane_valid == '0));

    // Word spacing per lane, checked with a saturating gap counter.
    localparam int GW = $clog2(RO_DIV + 1);
    for (genvar l = 0; l < N_PART; l++) begin : g_gap
        logic [GW-1:0] gap;
        always_ff @(posedge clk) begin
            if (!rst_n)
                gap <= GW'(RO_DIV);
            else if (lane_valid[l])
                gap <= '0;
            else if (gap < GW'(RO_DIV))
                gap <= gap + 1'b1;
        end
        p_word_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
            lane_valid[l] |-> (gap >= GW'(RO_DIV - 1)));
    end
endmodule

// File: tb/fe_readout_seq_test.sv
module fe_readout_seq_test;
    localparam int NP = 2, CPP = 3, EV = 2, CH = 2, DIV = 2, BUR = 5, GAP = 3;
    localparam int NCH = NP * CPP;
    localparam int FRAME = 1 + EV + EV * CH;
    localparam int AW = $clog2(FRAME);
    localparam int CW = $clog2(CPP + 1);
    localparam int PW = 1;

    // Vector: {parallel, chip mask[5:0]} with mask bit index = part*3+chip.
    localparam logic [6:0] VEC [0:5] = '{
        7'b0_000001, 7'b0_100101, 7'b1_100101,
        7'b1_111111, 7'b0_111111, 7'b1_001000
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_local = 1'b0, cfg_parallel = 1'b0;
    logic ext_trig = 1'b0, ext_start = 1'b0, ext_stop = 1'b0;
    logic [NCH-1:0] full = '0, set_req = '0;
    logic [NP*16-1:0] rd_data;
    logic [NP-1:0] rd_req, rd_last, lane_valid, lane_last;
    logic [NP*CW-1:0] rd_sel;
    logic [NP*AW-1:0] rd_addr;
    logic [NP*16-1:0] lane_data;
    logic [NP*PW-1:0] lane_tag;
    logic busy, acq_active, chip_trig, full_up;

    int n_checks = 0, n_errors = 0;
    logic finished = 1'b0;
    logic mon_en = 1'b0, cur_par = 1'b0, saw_both = 1'b0;
    logic [15:0] exp_data [0:1][0:63];
    logic        exp_last [0:1][0:63];
    int          exp_tag  [0:1][0:63];
    int          exp_n [0:1];
    int          got_n [0:1];

    always #5 clk = ~clk;

    fe_readout_seq #(
        .N_PART(NP), .CHIPS_PER_PART(CPP), .EVENTS(EV), .CHANNELS(CH),
        .RO_DIV(DIV), .BURST_CYC(BUR), .GAP_CYC(GAP)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cfg_local(cfg_local), .cfg_parallel(cfg_parallel),
        .ext_trig(ext_trig), .ext_start(ext_start), .ext_stop(ext_stop),
        .chip_full(full), .rd_data(rd_data), .rd_req(rd_req), .rd_sel(rd_sel),
        .rd_addr(rd_addr), .rd_last(rd_last), .lane_valid(lane_valid),
        .lane_data(lane_data), .lane_tag(lane_tag), .lane_last(lane_last),
        .busy(busy), .acq_active(acq_active), .chip_trig(chip_trig), .full_up(full_up)
    );

    function automatic logic [15:0] chip_word(int p, int c, int a);
        return 16'h5000 | 16'(p << 10) | 16'(c << 8) | 16'(a);
    endfunction

    // Chip model: combinational memory answer per partition.
    always_comb begin
        for (int p = 0; p < NP; p++)
            rd_data[p*16 +: 16] = chip_word(p, int'(rd_sel[p*CW +: CW]), int'(rd_addr[p*AW +: AW]));
    end

    // Chip flags: set by the bench, cleared when the last word is fetched.
    always @(posedge clk) begin
        logic [NCH-1:0] nf;
        if (!rst_n) full <= '0;
        else begin
            nf = full | set_req;
            for (int p = 0; p < NP; p++)
                if (rd_req[p] && rd_last[p]) nf[p*CPP + int'(rd_sel[p*CW +: CW])] = 1'b0;
            full <= nf;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Word monitor: compares lane output in order with the expected frames.
    always @(negedge clk) begin
        if (mon_en) begin
            if (lane_valid[0] && lane_valid[1]) saw_both <= 1'b1;
            for (int l = 0; l < NP; l++) begin
                if (lane_valid[l]) begin
                    if (got_n[l] >= exp_n[l]) chk("R3 extra word", 32'(got_n[l]), 32'(exp_n[l]));
                    else begin
                        chk("R1 word", 32'(lane_data[l*16 +: 16]), 32'(exp_data[l][got_n[l]]));
                        chk("R2 frame end", 32'(lane_last[l]), 32'(exp_last[l][got_n[l]]));
                        chk(cur_par ? "R5 tag" : "R4 tag", 32'(lane_tag[l*PW +: PW]), 32'(exp_tag[l][got_n[l]]));
                    end
                    got_n[l] = got_n[l] + 1;
                end
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_full(logic [NCH-1:0] m);
        set_req = m;
        step(1);
        set_req = '0;
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        step(1);
        while (busy && t < 3000) begin step(1); t++; end
        chk("R7 drain completes", 32'(busy), 32'd0);
    endtask

    task automatic build_expected(logic par, logic [NCH-1:0] m);
        int lane;
        exp_n[0] = 0; exp_n[1] = 0; got_n[0] = 0; got_n[1] = 0;
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < CPP; c++)
                if (m[p*CPP + c]) begin
                    lane = par ? p : 0;
                    for (int w = 0; w < FRAME; w++) begin
                        exp_data[lane][exp_n[lane]] = (w == 0) ? (16'hC000 | 16'(p*CPP + c)) : chip_word(p, c, w - 1);
                        exp_last[lane][exp_n[lane]] = (w == FRAME - 1);
                        exp_tag[lane][exp_n[lane]]  = p;
                        exp_n[lane]++;
                    end
                end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        int hi, lo;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R12: reset state
        chk("R12 busy", 32'(busy), 0);
        chk("R12 acq_active", 32'(acq_active), 0);
        chk("R12 lane_valid", 32'(lane_valid), 0);
        chk("R12 full_up", 32'(full_up), 0);
        chk("R12 chip_trig", 32'(chip_trig), 0);

        // Table walk: readout order, framing, lanes.
        for (int v = 0; v < 6; v++) begin
            cur_par = VEC[v][6];
            cfg_parallel = VEC[v][6];
            build_expected(VEC[v][6], VEC[v][5:0]);
            saw_both = 1'b0;
            mon_en = 1'b1;
            set_full(VEC[v][5:0]);
            wait_idle();
            step(2);
            mon_en = 1'b0;
            chk("R3 lane0 word count", 32'(got_n[0]), 32'(exp_n[0]));
            chk("R3 lane1 word count", 32'(got_n[1]), 32'(exp_n[1]));
            chk("R7 flags drained", 32'(full), 0);
            if (v == 3) chk("R5 lanes concurrent", 32'(saw_both), 1);
            if (v == 4) chk("R4 single lane", 32'(saw_both), 0);
        end

        // R8: start raises acquisition two edges later.
        ext_start = 1'b1; step(1); ext_start = 1'b0; step(1);
        chk("R8 start", 32'(acq_active), 1);
        // R9: trigger forwarded one edge later.
        ext_trig = 1'b1; step(1); ext_trig = 1'b0;
        chk("R9 trig forwarded", 32'(chip_trig), 1);
        step(1);
        chk("R9 trig single", 32'(chip_trig), 0);
        // R7: full during acquisition pauses then resumes.
        cfg_parallel = 1'b1;
        set_full(6'b000010);
        step(1);
        chk("R7 busy rises", 32'(busy), 1);
        chk("R10 full_up", 32'(full_up), 1);
        chk("R7 acq paused", 32'(acq_active), 0);
        wait_idle();
        step(1);
        chk("R7 acq resumes", 32'(acq_active), 1);
        // R8: stop
        ext_stop = 1'b1; step(1); ext_stop = 1'b0; step(1);
        chk("R8 stop", 32'(acq_active), 0);
        ext_trig = 1'b1; step(1); ext_trig = 1'b0;
        chk("R9 trig blocked", 32'(chip_trig), 0);
        // R8: start while busy is ignored.
        set_full(6'b100000);
        step(2);
        ext_start = 1'b1; step(1); ext_start = 1'b0;
        wait_idle();
        step(3);
        chk("R8 start ignored while busy", 32'(acq_active), 0);
        ext_start = 1'b1; step(1); ext_start = 1'b0; step(1);
        chk("R8 start accepted when idle", 32'(acq_active), 1);

        // R10/R11: local mode.
        cfg_local = 1'b1;
        step(2);
        set_full(6'b000100);
        step(1);
        chk("R10 full_up low in local", 32'(full_up), 0);
        wait_idle();
        step(1);
        while (acq_active) step(1);
        while (!acq_active) step(1);
        ext_stop = 1'b1; ext_start = 1'b1;
        hi = 0;
        while (acq_active && hi < 100) begin step(1); hi++; ext_stop = 1'b0; ext_start = 1'b0; end
        lo = 0;
        while (!acq_active && lo < 100) begin step(1); lo++; end
        chk("R11 burst length", 32'(hi), 32'(BUR));
        chk("R11 gap length", 32'(lo), 32'(GAP));

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule